// File: doc/BRIEF.md
# Root-Port Configuration Access Router

This block sits at the configuration entry of a PCIe root port. Each request names a target bus, device, function, register offset and access size. The block decides where the request goes. A request to the root bus is served by the port's own configuration space. A request to the bus directly below the port becomes a type 0 downstream access. A request to any deeper bus becomes a type 1 access. Both downstream kinds carry a packed routing identifier.

Requests whose target cannot exist are refused with a device-not-found status. This covers any device above 0 on the root bus or on the bus just below the port, and any bus other than the root while the link is down. Requests whose size is illegal, or whose offset is not a multiple of the size, are refused with a bad-register status. For an accepted access the block also produces the byte-lane enables inside the addressed dword. The data of an accepted access comes from the target that serves it, so the block drives zero on its own data output in that case.

Software sets the root bus number and the port's secondary bus number as static inputs. Requests enter through a valid/ready handshake. One response per request is returned one cycle after acceptance, on a second valid/ready handshake.

Top module: `cfg_route_top`

## Requirements
- R1: An accepted request (reqValid and reqReady high at a clock edge) raises rspValid after that edge. While rspValid is high and rspReady is low, every response field holds its value and reqReady is low.
- R2: While linkUp is low at acceptance, a request to any bus other than rootBusNum is refused with status 1 (not found).
- R3: A request to bus rootBusNum with a device number other than 0 is refused with status 1.
- R4: A request to bus secBusNum (when it differs from rootBusNum) with a device number other than 0 is refused with status 1.
- R5: A refused read (status 1, reqWrite low) returns rspRdata 0xFFFFFFFF. A refused write returns status 1 with rspRdata 0. Either way the target code is 3 (none).
- R6: An accepted request to bus rootBusNum is given target code 0 (local), status 0.
- R7: An accepted request to bus secBusNum is given target code 1 (type 0). An accepted request to any other non-root bus is given target code 2 (type 1).
- R8: Sizes 1, 2 and 4 bytes are legal, and the offset must be a multiple of the size. Otherwise status is 2 (bad register), target 3 and rspRdata 0. Status 1 takes precedence over status 2.
- R9: For target codes 1 and 2, rspRouteId holds bus in bits 31:24, device in bits 23:19, function in bits 18:16 and zeros below. For every other target it is zero.
- R10: For status 0, bit i of rspByteEn is set exactly for lanes offset[1:0] to offset[1:0]+size-1. For any other status rspByteEn is 0.
- R11: After reset rspValid is low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Target bus number |
| reqDev | input | 5 | Target device number |
| reqFunc | input | 3 | Target function number |
| reqOffset | input | 12 | Register byte offset |
| reqSize | input | 3 | Access size in bytes |
| linkUp | input | 1 | Link-up indication, sampled at acceptance |
| rootBusNum | input | 8 | Root bus number (software set) |
| secBusNum | input | 8 | Bus directly below the port (software set) |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response taken |
| rspWrite | output | 1 | Direction of the answered request |
| rspStatus | output | 2 | 0 ok, 1 not found, 2 bad register |
| rspTarget | output | 2 | 0 local, 1 type 0, 2 type 1, 3 none |
| rspRdata | output | 32 | Data produced by the router |
| rspRouteId | output | 32 | Packed routing identifier |
| rspByteEn | output | 4 | Byte lanes inside the dword |

## Verification
Every decision is due on the response registers in the cycle after the edge that accepts the request. The bench therefore drives a request on a falling edge and lets the next rising edge take it. It then compares all response fields on the following falling edge, with the expected values it computed at drive time. Held responses are checked over several falling edges with rspReady low, to show that the fields stay put and that reqReady stays low until the response is taken.

// File: rtl/cfgRoutePkg.sv
package cfgRoutePkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NOTFOUND = 2'd1,
    ST_BADREG   = 2'd2
  } statusE;

  typedef enum logic [1:0] {
    TG_LOCAL = 2'd0,
    TG_TYPE0 = 2'd1,
    TG_TYPE1 = 2'd2,
    TG_NONE  = 2'd3
  } targetE;

  typedef struct packed {
    logic load;    // capture a new decision
    logic retire;  // response taken, nothing new
  } ctrlStrobeS;
endpackage

// File: rtl/cfgRouteCtrl.sv
module cfgRouteCtrl
  import cfgRoutePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  input  logic       rspReady,
  output ctrlStrobeS strobe
);
  logic busy;
  logic accept;

  assign reqReady = !busy || rspReady;
  assign accept   = reqValid && reqReady;
  assign rspValid = busy;

  always_comb begin
    strobe.load   = accept;
    strobe.retire = busy && rspReady && !accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
    end else if (rspReady) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgRouteDp.sv
module cfgRouteDp
  import cfgRoutePkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeS        strobe,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FN_W-1:0]   reqFunc,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [2:0]        reqSize,
  input  logic              linkUp,
  input  logic [BUS_W-1:0]  rootBusNum,
  input  logic [BUS_W-1:0]  secBusNum,
  output logic              rspWrite,
  output statusE            rspStatus,
  output targetE            rspTarget,
  output logic [DATA_W-1:0] rspRdata,
  output logic [DATA_W-1:0] rspRouteId,
  output logic [DATA_W/8-1:0] rspByteEn
);
  localparam int ID_W  = BUS_W + DEV_W + FN_W;
  localparam int PAD_W = DATA_W - ID_W;
  localparam int LANES = DATA_W / 8;

  logic onRoot, onSec, notFound, sizeOk, misalign;
  logic [2:0] sizeMask;
  statusE nxtStatus;
  targetE nxtTarget;
  logic [DATA_W-1:0] nxtRdata, nxtRouteId;
  logic [LANES-1:0] nxtByteEn;
  logic [3:0] laneLo, laneHi;

  always_comb begin
    onRoot   = (reqBus == rootBusNum);
    onSec    = (reqBus == secBusNum) && !onRoot;
    notFound = (!onRoot && !linkUp) || ((onRoot || onSec) && (reqDev != '0));
    sizeOk   = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
    sizeMask = reqSize - 3'd1;
    misalign = |(reqOffset[2:0] & sizeMask);

    if (notFound)               nxtStatus = ST_NOTFOUND;
    else if (!sizeOk || misalign) nxtStatus = ST_BADREG;
    else                        nxtStatus = ST_OK;

    if (nxtStatus != ST_OK) nxtTarget = TG_NONE;
    else if (onRoot)        nxtTarget = TG_LOCAL;
    else if (onSec)         nxtTarget = TG_TYPE0;
    else                    nxtTarget = TG_TYPE1;

    nxtRdata = (nxtStatus == ST_NOTFOUND && !reqWrite) ? '1 : '0;

    if (nxtTarget == TG_TYPE0 || nxtTarget == TG_TYPE1)
      nxtRouteId = {reqBus, reqDev, reqFunc, {PAD_W{1'b0}}};
    else
      nxtRouteId = '0;

    laneLo = {2'b00, reqOffset[1:0]};
    laneHi = laneLo + {1'b0, reqSize};
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    localparam logic [3:0] LANE_IDX = 4'(lane);
    assign nxtByteEn[lane] = (nxtStatus == ST_OK) &&
                             (LANE_IDX >= laneLo) && (LANE_IDX < laneHi);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspWrite   <= 1'b0;
      rspStatus  <= ST_OK;
      rspTarget  <= TG_NONE;
      rspRdata   <= '0;
      rspRouteId <= '0;
      rspByteEn  <= '0;
    end else if (strobe.load) begin
      rspWrite   <= reqWrite;
      rspStatus  <= nxtStatus;
      rspTarget  <= nxtTarget;
      rspRdata   <= nxtRdata;
      rspRouteId <= nxtRouteId;
      rspByteEn  <= nxtByteEn;
    end else if (strobe.retire) begin
      rspWrite   <= 1'b0;
      rspStatus  <= ST_OK;
      rspTarget  <= TG_NONE;
      rspRdata   <= '0;
      rspRouteId <= '0;
      rspByteEn  <= '0;
    end
  end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
  import cfgRoutePkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FN_W-1:0]   reqFunc,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [2:0]        reqSize,
  input  logic              linkUp,
  input  logic [BUS_W-1:0]  rootBusNum,
  input  logic [BUS_W-1:0]  secBusNum,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspWrite,
  output logic [1:0]        rspStatus,
  output logic [1:0]        rspTarget,
  output logic [DATA_W-1:0] rspRdata,
  output logic [DATA_W-1:0] rspRouteId,
  output logic [DATA_W/8-1:0] rspByteEn
);
  ctrlStrobeS strobe;
  statusE     statusQ;
  targetE     targetQ;

  cfgRouteCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady), .strobe(strobe)
  );

  cfgRouteDp #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc),
    .reqOffset(reqOffset), .reqSize(reqSize), .linkUp(linkUp),
    .rootBusNum(rootBusNum), .secBusNum(secBusNum), .rspWrite(rspWrite),
    .rspStatus(statusQ), .rspTarget(targetQ), .rspRdata(rspRdata),
    .rspRouteId(rspRouteId), .rspByteEn(rspByteEn)
  );

  assign rspStatus = statusQ;
  assign rspTarget = targetQ;
endmodule

// File: rtl/cfgRouteChk.sv
module cfgRouteChk #(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [BUS_W-1:0]  reqBus,
  input logic [DEV_W-1:0]  reqDev,
  input logic              linkUp,
  input logic [BUS_W-1:0]  rootBusNum,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rspWrite,
  input logic [1:0]        rspStatus,
  input logic [1:0]        rspTarget,
  input logic [DATA_W-1:0] rspRdata,
  input logic [DATA_W/8-1:0] rspByteEn
);
  // R1
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid);
  // R1
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspStatus) &&
      $stable(rspTarget) && $stable(rspRdata) && $stable(rspByteEn));
  // R2
  link_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && (reqBus != rootBusNum) && !linkUp |=> rspStatus == 2'd1);
  // R3
  root_dev_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && (reqBus == rootBusNum) && (reqDev != '0) |=> rspStatus == 2'd1);
  // R5
  nf_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus == 2'd1 && !rspWrite |-> rspRdata == '1 && rspTarget == 2'd3);
  // R8
  bad_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus == 2'd2 |-> rspTarget == 2'd3 && rspRdata == '0);
  // R10
  be_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus != 2'd0 |-> rspByteEn == '0);
  // R11
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> reqReady);
endmodule

bind cfg_route_top cfgRouteChk #(.BUS_W(BUS_W), .DEV_W(DEV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqBus(reqBus), .reqDev(reqDev), .linkUp(linkUp), .rootBusNum(rootBusNum),
  .rspValid(rspValid), .rspReady(rspReady), .rspWrite(rspWrite),
  .rspStatus(rspStatus), .rspTarget(rspTarget), .rspRdata(rspRdata),
  .rspByteEn(rspByteEn)
);

// File: tb/sim_cfg_route_top.sv
`timescale 1ns/1ps
module sim_cfg_route_top;
  localparam logic [7:0] ROOT = 8'h10;
  localparam logic [7:0] SEC  = 8'h11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, linkUp = 1'b0, rspReady = 1'b1;
  logic [7:0] reqBus = '0;
  logic [4:0] reqDev = '0;
  logic [2:0] reqFunc = '0;
  logic [11:0] reqOffset = '0;
  logic [2:0] reqSize = 3'd4;
  logic [7:0] rootBusNum = ROOT, secBusNum = SEC;
  logic reqReady, rspValid, rspWrite;
  logic [1:0] rspStatus, rspTarget;
  logic [31:0] rspRdata, rspRouteId;
  logic [3:0] rspByteEn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cfg_route_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc),
    .reqOffset(reqOffset), .reqSize(reqSize), .linkUp(linkUp),
    .rootBusNum(rootBusNum), .secBusNum(secBusNum), .rspValid(rspValid),
    .rspReady(rspReady), .rspWrite(rspWrite), .rspStatus(rspStatus),
    .rspTarget(rspTarget), .rspRdata(rspRdata), .rspRouteId(rspRouteId),
    .rspByteEn(rspByteEn)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected results computed from the requirements.
  logic [1:0] eStatus, eTarget;
  logic [31:0] eRdata, eRoute;
  logic [3:0] eBe;

  task automatic model(logic wr, logic [7:0] bus, logic [4:0] dev, logic [2:0] fn,
                       logic [11:0] off, logic [2:0] sz, logic lu);
    bit rootB = (bus == ROOT);
    bit secB  = (bus == SEC);
    bit nf    = (!rootB && !lu) || ((rootB || secB) && dev != 0);       // R2 R3 R4
    bit legal = (sz == 1 || sz == 2 || sz == 4) && (int'(off) % int'(sz == 0 ? 1 : sz) == 0); // R8
    eStatus = nf ? 2'd1 : (!legal ? 2'd2 : 2'd0);
    eTarget = (eStatus != 0) ? 2'd3 : (rootB ? 2'd0 : (secB ? 2'd1 : 2'd2)); // R6 R7
    eRdata  = (eStatus == 1 && !wr) ? 32'hFFFF_FFFF : 32'h0;                // R5
    eRoute  = (eTarget == 1 || eTarget == 2) ? {bus, dev, fn, 16'h0} : 32'h0; // R9
    eBe = '0;                                                                // R10
    if (eStatus == 0)
      for (int i = 0; i < 4; i++)
        if (i >= int'(off[1:0]) && i < int'(off[1:0]) + int'(sz)) eBe[i] = 1'b1;
  endtask

  task automatic compare(string tag);
    chk({tag, " R1 valid"}, {31'h0, rspValid}, 32'h1);
    chk({tag, " status"}, {30'h0, rspStatus}, {30'h0, eStatus});
    chk({tag, " R7 target"}, {30'h0, rspTarget}, {30'h0, eTarget});
    chk({tag, " R5 rdata"}, rspRdata, eRdata);
    chk({tag, " R9 routeId"}, rspRouteId, eRoute);
    chk({tag, " R10 byteEn"}, {28'h0, rspByteEn}, {28'h0, eBe});
  endtask

  task automatic access(string tag, logic wr, logic [7:0] bus, logic [4:0] dev,
                        logic [2:0] fn, logic [11:0] off, logic [2:0] sz, logic lu);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBus = bus; reqDev = dev; reqFunc = fn;
    reqOffset = off; reqSize = sz; linkUp = lu;
    model(wr, bus, dev, fn, off, sz, lu);
    @(negedge clk);
    reqValid = 1'b0;
    linkUp = ~lu;  // sampled only at acceptance
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rspValid", {31'h0, rspValid}, 32'h0);
    chk("R11 reqReady", {31'h0, reqReady}, 32'h1);
    rstN = 1'b1;

    access("R6 root read",        1'b0, ROOT, 5'd0, 3'd2, 12'h010, 3'd4, 1'b0);
    access("R3 root dev1",        1'b0, ROOT, 5'd1, 3'd0, 12'h000, 3'd4, 1'b1);
    access("R4 sec dev3",         1'b0, SEC,  5'd3, 3'd0, 12'h000, 3'd4, 1'b1);
    access("R7 sec type0",        1'b1, SEC,  5'd0, 3'd5, 12'h006, 3'd2, 1'b1);
    access("R7 deep type1",       1'b0, 8'h22, 5'd7, 3'd3, 12'h003, 3'd1, 1'b1);
    access("R2 link down",        1'b0, 8'h22, 5'd0, 3'd0, 12'h000, 3'd4, 1'b0);
    access("R5 nf write",         1'b1, 8'h22, 5'd0, 3'd0, 12'h000, 3'd4, 1'b0);
    access("R8 misalign",         1'b0, ROOT, 5'd0, 3'd0, 12'h002, 3'd4, 1'b0);
    access("R8 size3",            1'b0, SEC,  5'd0, 3'd0, 12'h000, 3'd3, 1'b1);
    access("R8 nf precedence",    1'b0, ROOT, 5'd2, 3'd0, 12'h001, 3'd4, 1'b0);
    access("R10 byte lane 3",     1'b1, ROOT, 5'd0, 3'd0, 12'h0FF, 3'd1, 1'b0);
    access("R9 max ids",          1'b0, 8'hFF, 5'd31, 3'd7, 12'hFFC, 3'd4, 1'b1);

    // R1 back-pressure: response holds, reqReady low
    @(negedge clk);
    rspReady = 1'b0;
    reqValid = 1'b1; reqWrite = 1'b0; reqBus = SEC; reqDev = 5'd0; reqFunc = 3'd1;
    reqOffset = 12'h004; reqSize = 3'd4; linkUp = 1'b1;
    model(1'b0, SEC, 5'd0, 3'd1, 12'h004, 3'd4, 1'b1);
    @(negedge clk);
    reqBus = 8'h40; reqDev = 5'd9;  // offered but must not be taken
    compare("R1 held0");
    chk("R1 ready low", {31'h0, reqReady}, 32'h0);
    @(negedge clk);
    compare("R1 held1");
    reqValid = 1'b0;
    rspReady = 1'b1;
    @(negedge clk);
    chk("R1 retired", {31'h0, rspValid}, 32'h0);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] b;
      logic [4:0] d;
      logic [2:0] sz;
      logic [11:0] off;
      int pick = int'($urandom_range(3, 0));
      b  = (pick == 0) ? ROOT : (pick == 1) ? SEC : 8'($urandom_range(255, 0));
      d  = ($urandom_range(3, 0) == 0) ? 5'($urandom_range(31, 0)) : 5'd0;
      pick = int'($urandom_range(4, 0));
      sz = (pick == 0) ? 3'($urandom_range(7, 0)) : (pick == 1) ? 3'd1 : (pick == 2) ? 3'd2 : 3'd4;
      off = 12'($urandom_range(4095, 0));
      if ($urandom_range(1, 0) == 1) off = off & ~12'(sz == 0 ? 0 : sz - 1);
      access("RND R2 R6 R7 R8", 1'($urandom_range(1, 0)), b, d,
             3'($urandom_range(7, 0)), off, sz, 1'($urandom_range(3, 0) != 0));
    end

    summary();
  end
endmodule